// File: doc/BRIEF.md
# Linked-List Queue Manager

This block keeps a set of descriptor queues. Each queue is a singly linked list held in a word-addressed memory. Every list element is one memory word at the element's own address, and that word holds the address of the next element. The same memory holds a queue table at its top end, with two words per queue: the head pointer at `2**AW - 2*NQ + 2*q` and the tail pointer one word above it. The pointer value all ones (`NULL`) marks an empty head or tail and the end of a list.

A client issues one command at a time. An enqueue (`cmd_op` = 0) appends the element at `cmd_addr` to queue `cmd_queue`. A dequeue (`cmd_op` = 1) removes the head of queue `cmd_queue` and returns its address, or flags that the queue was empty. Each command becomes a chain of dependent memory accesses to a memory model that has a fixed read latency of `LAT` cycles. The controller waits for each read to return before it issues the access that depends on it. `busy` stays high until the chain ends, and new commands are held off in the meantime, so every list update is atomic and commands complete in arrival order.

After reset the block spends `2*NQ` cycles writing `NULL` into every table word, so all queues start empty. Element addresses must lie below the table region.

Top module: `llq_mgr`

## Requirements
- R1: From the release of reset, `busy` is high and `cmd_ready` is low for exactly `2*NQ` cycles. After that every queue is empty.
- R2: Dequeues of one queue return the element addresses in the order they were enqueued, with `rsp_empty` = 0.
- R3: Queues are independent. Commands to one queue never change the contents or order of another.
- R4: A dequeue of an empty queue gives `rsp_empty` = 1, performs no memory write, and leaves every queue unchanged.
- R5: Removing the last element leaves the queue empty. A later enqueue to that queue makes the new element both head and tail.
- R6: An enqueue keeps `busy` high for `4+LAT` cycles, starting in the cycle after acceptance.
- R7: A dequeue keeps `busy` high for `3+2*LAT` cycles when elements remain afterwards, `4+2*LAT` when it removes the last element, and `1+LAT` when the queue is empty.
- R8: `cmd_ready` is low whenever `busy` is high. A command held valid during that time is accepted at the first clock edge after `busy` falls.
- R9: Each dequeue, and no enqueue, gives exactly one `rsp_valid` pulse of one cycle. The pulse comes in the first cycle with `busy` low, and `rsp_addr` and `rsp_empty` are valid with it.
- R10: At most one memory read is outstanding, and read data only ever returns while the controller is waiting for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted when high together with cmd_valid |
| cmd_op | input | 1 | 0 = enqueue, 1 = dequeue |
| cmd_queue | input | QW | Queue number |
| cmd_addr | input | AW | Element address for an enqueue |
| busy | output | 1 | Command sequence or table clearing in progress |
| rsp_valid | output | 1 | One-cycle dequeue result strobe |
| rsp_empty | output | 1 | Dequeued queue was empty |
| rsp_addr | output | AW | Address of the removed element |

## Verification
A single queue is filled and drained past empty. This distinguishes the head and tail pointer paths, and separates the mid-list, last-element and empty cases of a dequeue by their busy lengths. Enqueues and dequeues interleaved across two queues expose any crossed table entry. A queue that is drained and then refilled shows whether the tail is cleared correctly. A dequeue of an empty queue placed between live operations shows that the empty path disturbs nothing. A command held valid during a busy phase checks the back-pressure and the ordering of accepted commands.

// File: rtl/llq_pkg.sv
package llq_pkg;
  typedef enum logic [3:0] {
    S_INIT, S_IDLE,
    S_ECLR, S_ERDT, S_EWT, S_ELNK, S_ETAIL,
    S_DRDH, S_DWH, S_DRDN, S_DWN, S_DWHEAD, S_DWTAIL
  } llq_state_e;

  localparam logic OP_ENQ = 1'b0;
  localparam logic OP_DEQ = 1'b1;
endpackage

// File: rtl/llq_sram.sv
module llq_sram #(
  parameter int AW  = 8,
  parameter int LAT = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] wdata,
  output logic [AW-1:0] rdata,
  output logic          rvalid
);
  localparam int DEPTH = 1 << AW;

  logic [AW-1:0] mem [DEPTH];
  logic [LAT-1:0] vpipe;
  logic [AW-1:0]  dpipe [LAT];

  always_ff @(posedge clk) begin
    if (req && we) mem[addr] <= wdata;
    dpipe[0] <= mem[addr];
  end

  always_ff @(posedge clk) begin
    if (rst) vpipe[0] <= 1'b0;
    else     vpipe[0] <= req && !we;
  end

  // extra output stages model the fixed access latency
  for (genvar g = 1; g < LAT; g++) begin : g_lat
    always_ff @(posedge clk) begin
      if (rst) vpipe[g] <= 1'b0;
      else     vpipe[g] <= vpipe[g-1];
      dpipe[g] <= dpipe[g-1];
    end
  end

  assign rdata  = dpipe[LAT-1];
  assign rvalid = vpipe[LAT-1];
endmodule

// File: rtl/llq_ctrl.sv
module llq_ctrl
  import llq_pkg::*;
#(
  parameter int AW = 8,
  parameter int NQ = 4,
  parameter int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_op,
  input  logic [QW-1:0] cmd_queue,
  input  logic [AW-1:0] cmd_addr,
  output logic          busy,
  output logic          rsp_valid,
  output logic          rsp_empty,
  output logic [AW-1:0] rsp_addr,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] mem_wdata,
  input  logic [AW-1:0] mem_rdata,
  input  logic          mem_rvalid
);
  localparam int DEPTH    = 1 << AW;
  localparam int TBL_BASE = DEPTH - 2 * NQ;
  localparam int CW       = (2 * NQ > 1) ? $clog2(2 * NQ) : 1;
  localparam logic [AW-1:0] NULLP = '1;

  llq_state_e    st;
  logic [QW-1:0] q_q;
  logic [AW-1:0] elem_q, ptr_q, nxt_q;
  logic [CW-1:0] init_cnt;
  logic [AW-1:0] head_a, tail_a;
  logic          accept;

  assign head_a    = AW'(TBL_BASE + 2 * int'(q_q));
  assign tail_a    = head_a + AW'(1);
  assign busy      = (st != S_IDLE);
  assign cmd_ready = (st == S_IDLE);
  assign accept    = cmd_valid && cmd_ready;

  // memory access issued by the current step of the sequence
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (st)
      S_INIT:   begin mem_req = 1'b1; mem_we = 1'b1;
                      mem_addr = AW'(TBL_BASE + int'(init_cnt)); mem_wdata = NULLP; end
      S_ECLR:   begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = elem_q; mem_wdata = NULLP; end
      S_ERDT:   begin mem_req = 1'b1; mem_addr = tail_a; end
      S_ELNK:   begin mem_req = 1'b1; mem_we = 1'b1;
                      mem_addr = (ptr_q == NULLP) ? head_a : ptr_q; mem_wdata = elem_q; end
      S_ETAIL:  begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = tail_a; mem_wdata = elem_q; end
      S_DRDH:   begin mem_req = 1'b1; mem_addr = head_a; end
      S_DRDN:   begin mem_req = 1'b1; mem_addr = ptr_q; end
      S_DWHEAD: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = head_a; mem_wdata = nxt_q; end
      S_DWTAIL: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = tail_a; mem_wdata = NULLP; end
      default:  ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_INIT;
      init_cnt  <= '0;
      rsp_valid <= 1'b0;
      rsp_empty <= 1'b0;
      rsp_addr  <= '0;
      q_q       <= '0;
      elem_q    <= '0;
      ptr_q     <= '0;
      nxt_q     <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (st)
        S_INIT: begin
          init_cnt <= init_cnt + CW'(1);
          if (init_cnt == CW'(2 * NQ - 1)) st <= S_IDLE;
        end
        S_IDLE: if (accept) begin
          q_q    <= cmd_queue;
          elem_q <= cmd_addr;
          st     <= (cmd_op == OP_ENQ) ? S_ECLR : S_DRDH;
        end
        S_ECLR:  st <= S_ERDT;
        S_ERDT:  st <= S_EWT;
        S_EWT:   if (mem_rvalid) begin ptr_q <= mem_rdata; st <= S_ELNK; end
        S_ELNK:  st <= S_ETAIL;
        S_ETAIL: st <= S_IDLE;
        S_DRDH:  st <= S_DWH;
        S_DWH: if (mem_rvalid) begin
          if (mem_rdata == NULLP) begin
            rsp_valid <= 1'b1;
            rsp_empty <= 1'b1;
            rsp_addr  <= NULLP;
            st        <= S_IDLE;
          end else begin
            ptr_q <= mem_rdata;
            st    <= S_DRDN;
          end
        end
        S_DRDN: st <= S_DWN;
        S_DWN:  if (mem_rvalid) begin nxt_q <= mem_rdata; st <= S_DWHEAD; end
        S_DWHEAD: begin
          if (nxt_q == NULLP) st <= S_DWTAIL;
          else begin
            rsp_valid <= 1'b1; rsp_empty <= 1'b0; rsp_addr <= ptr_q; st <= S_IDLE;
          end
        end
        S_DWTAIL: begin
          rsp_valid <= 1'b1; rsp_empty <= 1'b0; rsp_addr <= ptr_q; st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_RVALID_IN_WAIT: assert property (@(posedge clk) disable iff (rst)
    mem_rvalid |-> (st == S_EWT || st == S_DWH || st == S_DWN)); // R10
  AST_EMPTY_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (st == S_DWH && mem_rvalid && mem_rdata == NULLP) |=> !mem_req); // R4
  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !busy); // R9
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R9
  AST_NO_NULL_DEREF: assert property (@(posedge clk) disable iff (rst)
    (st == S_DRDN) |-> (ptr_q != NULLP)); // R5
endmodule

// File: rtl/llq_mgr.sv
module llq_mgr #(
  parameter int AW  = 8,
  parameter int NQ  = 4,
  parameter int LAT = 2,
  parameter int QW  = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_op,
  input  logic [QW-1:0] cmd_queue,
  input  logic [AW-1:0] cmd_addr,
  output logic          busy,
  output logic          rsp_valid,
  output logic          rsp_empty,
  output logic [AW-1:0] rsp_addr
);
  logic          m_req, m_we, m_rvalid;
  logic [AW-1:0] m_addr, m_wdata, m_rdata;

  llq_ctrl #(.AW(AW), .NQ(NQ), .QW(QW)) u_ctrl (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_queue(cmd_queue), .cmd_addr(cmd_addr),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_empty(rsp_empty), .rsp_addr(rsp_addr),
    .mem_req(m_req), .mem_we(m_we), .mem_addr(m_addr), .mem_wdata(m_wdata),
    .mem_rdata(m_rdata), .mem_rvalid(m_rvalid)
  );

  llq_sram #(.AW(AW), .LAT(LAT)) u_mem (
    .clk(clk), .rst(rst), .req(m_req), .we(m_we), .addr(m_addr),
    .wdata(m_wdata), .rdata(m_rdata), .rvalid(m_rvalid)
  );
endmodule

// File: tb/llq_mgr_test.sv
`timescale 1ns/1ps
module llq_mgr_test;
  localparam int AW = 8, NQ = 4, LAT = 2, QW = 2;
  localparam int ENQ_CYC = 4 + LAT;
  localparam int DEQ_MID = 3 + 2 * LAT;
  localparam int DEQ_LST = 4 + 2 * LAT;
  localparam int DEQ_EMP = 1 + LAT;

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_valid = 1'b0, cmd_op = 1'b0;
  logic [QW-1:0] cmd_queue = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic cmd_ready, busy, rsp_valid, rsp_empty;
  logic [AW-1:0] rsp_addr;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  llq_mgr #(.AW(AW), .NQ(NQ), .LAT(LAT), .QW(QW)) uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_queue(cmd_queue), .cmd_addr(cmd_addr),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_empty(rsp_empty), .rsp_addr(rsp_addr)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // issue a command, wait until it completes; returns busy cycles and response
  task automatic run_cmd(input logic op, input int q, input int a,
                         output int cyc, output int rv, output int re, output int ra);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_queue = QW'(q); cmd_addr = AW'(a);
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    cyc = 0;
    while (busy) begin cyc++; @(negedge clk); end
    rv = int'(rsp_valid); re = int'(rsp_empty); ra = int'(rsp_addr);
  endtask

  task automatic enq(input string req, input int q, input int a);
    int c, v, e, r;
    run_cmd(1'b0, q, a, c, v, e, r);
    check({req, " R6 enqueue busy cycles"}, c, ENQ_CYC);
    check({req, " R9 no response after enqueue"}, v, 0);
  endtask

  task automatic deq(input string req, input int q, input int exp_addr, input int exp_cyc);
    int c, v, e, r;
    run_cmd(1'b1, q, 0, c, v, e, r);
    check({req, " R7 dequeue busy cycles"}, c, exp_cyc);
    check({req, " R9 response strobe"}, v, 1);
    check({req, " empty flag"}, e, (exp_addr < 0) ? 1 : 0);
    if (exp_addr >= 0) check({req, " dequeued address"}, r, exp_addr);
  endtask

  task automatic t_reset;
    int c;
    @(negedge clk);
    rst = 1'b0;
    c = 0;
    check("R1 ready low after reset", int'(cmd_ready), 0);
    while (busy) begin c++; @(negedge clk); end
    check("R1 clear cycles", c, 2 * NQ);
    for (int q = 0; q < NQ; q++) deq("R1", q, -1, DEQ_EMP);
  endtask

  task automatic t_fifo;
    enq("R2", 1, 10); enq("R2", 1, 20); enq("R2", 1, 30);
    deq("R2", 1, 10, DEQ_MID);
    deq("R2", 1, 20, DEQ_MID);
    deq("R5", 1, 30, DEQ_LST);
    deq("R5", 1, -1, DEQ_EMP);
  endtask

  task automatic t_interleave;
    enq("R3", 0, 5); enq("R3", 2, 100); enq("R3", 0, 6);
    deq("R3", 2, 100, DEQ_LST);
    enq("R3", 2, 101); enq("R3", 0, 7);
    deq("R3", 0, 5, DEQ_MID);
    deq("R3", 2, 101, DEQ_LST);
    deq("R3", 0, 6, DEQ_MID);
    deq("R3", 0, 7, DEQ_LST);
    deq("R3", 2, -1, DEQ_EMP);
  endtask

  task automatic t_refill;
    enq("R5", 3, 200);
    deq("R5", 3, 200, DEQ_LST);
    enq("R5", 3, 201); enq("R5", 3, 0);
    deq("R5", 3, 201, DEQ_MID);
    deq("R5", 3, 0, DEQ_LST);
  endtask

  task automatic t_empty_quiet;
    enq("R4", 0, 40); enq("R4", 0, 41);
    deq("R4", 3, -1, DEQ_EMP);
    deq("R4", 1, -1, DEQ_EMP);
    deq("R4", 0, 40, DEQ_MID);
    deq("R4", 3, -1, DEQ_EMP);
    deq("R4", 0, 41, DEQ_LST);
  endtask

  task automatic t_backpressure;
    int w;
    bit ready_seen_busy;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 1'b0; cmd_queue = 2'd2; cmd_addr = 8'd77;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_op = 1'b0; cmd_queue = 2'd2; cmd_addr = 8'd78;
    w = 0; ready_seen_busy = 0;
    while (!cmd_ready) begin
      if (!busy) ready_seen_busy = 1;
      w++; @(negedge clk);
    end
    check("R8 held command wait cycles", w, ENQ_CYC);
    check("R8 ready low only while busy", int'(ready_seen_busy), 0);
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R8 held command accepted", int'(busy), 1);
    while (busy) @(negedge clk);
    deq("R8", 2, 77, DEQ_MID);
    deq("R8", 2, 78, DEQ_LST);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset;
    t_fifo;
    t_interleave;
    t_refill;
    t_empty_quiet;
    t_backpressure;
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule